// File: doc/BRIEF.md
# Carry-Select Adder with Excess-One Converters

This block adds two 16-bit operands and a carry-in, and returns a 16-bit sum and a carry-out. The operand bits are split into five groups. The least significant group is a plain ripple-carry adder that takes the external carry-in. Each higher group works in three steps:

- It forms its sum with the incoming carry taken as zero, using a ripple-carry adder.
- It forms the "carry was one" alternative by passing that sum, together with the group's carry, through an increment-by-one (excess-one) converter. There is no second ripple adder.
- A multiplexer picks one of the two results, steered by the carry arriving from the group below.

The result can be registered once, which is the default, or passed straight through. This lets the adder sit either at the end of a pipeline stage or inside combinational logic.

The group widths grow toward the most significant end. The wider upper groups then have more time to settle their local sums and increments while the select carry travels up the short lower groups.

Top module: `bec_select_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals the 17-bit value `a_i + b_i + cin_i` for every input combination.
- R2: With `REG_OUT = 1` (the default), the outputs change only at a rising clock edge. They show the result of the inputs present at that edge, so the latency is one cycle.
- R3: Each converter of width m returns its input plus one, modulo 2^m. Bit 0 is the inverse of input bit 0, and bit k is input bit k XOR the AND of all lower input bits. The carry of a group (sum bit 16 for the top group) therefore comes from the converter whenever the group's plain result is all ones and the incoming carry is one.
- R4: When the carry into a select group is 0, the group outputs its plain ripple result. When that carry is 1, it outputs the incremented result.
- R5: The groups are 2, 2, 3, 4 and 5 bits wide, starting from bit 0, so their top bits are 1, 3, 6, 10 and 15. The carry leaving each group equals the carry out of the partial sum of all bits up to that group's top bit, including `cin_i`. A carry-in of 1 added to an operand whose low k bits are all ones gives exactly bit k set, for every k from 1 to 16.
- R6: While `rst_n` is low, the registered sum and carry-out are 0.
- R7: The external carry-in enters only the lowest group and travels through all five groups. For example, `0xFFFF + 0x0000 + 1` gives sum 0 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset for the output register |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry-in to the lowest group |
| sum_o | output | 16 | Sum |
| cout_o | output | 1 | Carry-out of the top group |

## Verification
The clocked result check assumes that the operands and the carry-in are stable and known at every rising edge after reset. The bench therefore changes them only on the falling edge and holds them for a full cycle. The immediate checks inside the groups and converters assume only that the inputs are two-state, and every stimulus value is fully defined. The directed patterns place runs of ones that end exactly at each group boundary, so that every select multiplexer is seen in both positions and every converter is seen wrapping.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    localparam int DATA_W  = 16;
    localparam int NUM_GRP = 5;

    // Width of group idx, least significant group first.
    // The widths grow upward to match the carry arrival time.
    function automatic int grp_width(input int idx);
        case (idx)
            0:       return 2;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            default: return 5;
        endcase
    endfunction

    // Bit position of the lowest bit of group idx.
    function automatic int grp_base(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) begin
            acc += grp_width(k);
        end
        return acc;
    endfunction

    // Registered result of the adder: sum and carry-out.
    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic              carry;
    } bsa_result_t;

endpackage

// File: rtl/bsa_ripple.sv
// N-bit ripple-carry adder.
// With cin tied to 0, bit 0 reduces to a half adder, so a 2-bit group
// becomes one half adder plus one full adder.
module bsa_ripple #(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] s,
    output logic         co
);

    logic [N:0] chain;

    assign chain[0] = cin;

    for (genvar k = 0; k < N; k++) begin : g_bit
        logic prop;
        assign prop         = a[k] ^ b[k];
        assign s[k]         = prop ^ chain[k];
        assign chain[k+1]   = (a[k] & b[k]) | (chain[k] & prop);
    end

    assign co = chain[N];

    // The bit-level chain must agree with an arithmetic add.
    always_comb begin
        AST_RIPPLE_SUM: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin})); // R1
    end

endmodule

// File: rtl/bsa_incr.sv
// M-bit excess-one converter: adds one using a prefix AND and an XOR per bit.
module bsa_incr #(
    parameter int M = 3
) (
    input  logic [M-1:0] din,
    output logic [M-1:0] dout
);

    logic [M:0] all_ones_below;

    assign all_ones_below[0] = 1'b1;

    for (genvar k = 0; k < M; k++) begin : g_bit
        assign dout[k]             = din[k] ^ all_ones_below[k];
        assign all_ones_below[k+1] = all_ones_below[k] & din[k];
    end

    always_comb begin
        AST_INC_PLUS_ONE: assert (dout == din + 1'b1);            // R3
        AST_INC_LSB_INV:  assert (dout[0] == ~din[0]);            // R3
    end

endmodule

// File: rtl/bsa_group.sv
// One select group: a ripple sum with carry-in 0, an excess-one copy of it,
// and a multiplexer steered by the carry from the group below.
module bsa_group #(
    parameter int N = 3
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         csel,
    output logic [N-1:0] s,
    output logic         co
);

    localparam int M = N + 1;

    logic [N-1:0] plain_s;
    logic         plain_co;
    logic [M-1:0] bumped;

    bsa_ripple #(.N(N)) u_rca (
        .a   (a),
        .b   (b),
        .cin (1'b0),
        .s   (plain_s),
        .co  (plain_co)
    );

    bsa_incr #(.M(M)) u_bec (
        .din  ({plain_co, plain_s}),
        .dout (bumped)
    );

    always_comb begin
        if (csel) begin
            {co, s} = bumped;
        end else begin
            {co, s} = {plain_co, plain_s};
        end
    end

    always_comb begin
        if (!csel) begin
            AST_SEL_PLAIN: assert ({co, s} == ({1'b0, a} + {1'b0, b}));                  // R4
        end else begin
            AST_SEL_BUMP:  assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, 1'b1})); // R4
        end
    end

endmodule

// File: rtl/bec_select_adder.sv
module bec_select_adder
    import bsa_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);

    localparam int LOW_W = grp_width(0);

    // gcarry[g] is the carry entering group g; gcarry[NUM_GRP] is the carry-out.
    logic [NUM_GRP:0]  gcarry;
    logic [DATA_W-1:0] comb_sum;

    assign gcarry[0] = cin_i;

    // Lowest group: plain ripple adder fed by the external carry-in.
    bsa_ripple #(.N(LOW_W)) u_low (
        .a   (a_i[LOW_W-1:0]),
        .b   (b_i[LOW_W-1:0]),
        .cin (gcarry[0]),
        .s   (comb_sum[LOW_W-1:0]),
        .co  (gcarry[1])
    );

    // Select groups above it.
    for (genvar g = 1; g < NUM_GRP; g++) begin : g_sel
        localparam int GW  = grp_width(g);
        localparam int LSB = grp_base(g);
        bsa_group #(.N(GW)) u_grp (
            .a    (a_i[LSB +: GW]),
            .b    (b_i[LSB +: GW]),
            .csel (gcarry[g]),
            .s    (comb_sum[LSB +: GW]),
            .co   (gcarry[g+1])
        );
    end

    // Each group carry must match the carry of the partial sum up to its top bit.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_bnd
        localparam int HI = grp_base(g) + grp_width(g) - 1;
        logic [HI+1:0] part;
        always_comb begin
            part = {1'b0, a_i[HI:0]} + {1'b0, b_i[HI:0]} + {{(HI+1){1'b0}}, cin_i};
            AST_GROUP_CARRY: assert (gcarry[g+1] == part[HI+1]); // R5
        end
    end

    if (REG_OUT) begin : g_reg
        bsa_result_t res_d, res_q;
        logic        seen_d, seen_q;

        always_comb begin
            res_d.sum   = comb_sum;
            res_d.carry = gcarry[NUM_GRP];
            seen_d      = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q  <= '0;
                seen_q <= 1'b0;
            end else begin
                res_q  <= res_d;
                seen_q <= seen_d;
            end
        end

        assign sum_o  = res_q.sum;
        assign cout_o = res_q.carry;

        AST_REG_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q |-> ({cout_o, sum_o} ==
                ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{DATA_W{1'b0}}, $past(cin_i)})));  // R2
        AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |=> (sum_o == '0 && !cout_o));                                             // R6
    end else begin : g_comb
        assign sum_o  = comb_sum;
        assign cout_o = gcarry[NUM_GRP];
    end

    // The carry-out must come from the top group's selection.
    always_comb begin
        AST_FULL_SUM: assert ({gcarry[NUM_GRP], comb_sum} ==
            ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i}));                          // R1
    end

endmodule

// File: tb/bec_select_adder_test.sv
module bec_select_adder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bec_select_adder uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    function automatic logic [16:0] ref_add(logic [15:0] x, logic [15:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {16'b0, c};
    endfunction

    task automatic check(string req, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive on a falling edge; the result is registered at the next rising
    // edge and sampled on the falling edge after it.
    task automatic drive(string req, logic [15:0] x, logic [15:0] y, logic c);
        @(negedge clk);
        a = x; b = y; cin = c;
        @(negedge clk);
        check(req, {cout, sum}, ref_add(x, y, c));
    endtask

    // Group top bits for the 2,2,3,4,5 partition.
    function automatic int grp_top(int g);
        case (g)
            0:       return 1;
            1:       return 3;
            2:       return 6;
            3:       return 10;
            default: return 15;
        endcase
    endfunction

    initial begin
        logic [16:0] held;
        void'($urandom(32'h1F2E3D4C));

        // R6: reset holds the outputs at zero, even with active inputs.
        a = 16'hFFFF; b = 16'h0001; cin = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 reset", {cout, sum}, 17'h0);
        rst_n = 1'b1;

        // R7: carry-in travels through all groups.
        drive("R7 full carry", 16'hFFFF, 16'h0000, 1'b1);
        drive("R7 cin only",   16'h0000, 16'h0000, 1'b1);
        drive("R7 max",        16'hFFFF, 16'hFFFF, 1'b1);
        drive("R7 no cin",     16'hFFFF, 16'hFFFF, 1'b0);

        // R5: a run of k ones plus cin gives bit k set.
        for (int k = 1; k <= 16; k++) begin
            logic [16:0] ones;
            ones = (17'h1 << k) - 17'h1;
            drive("R5 run", ones[15:0], 16'h0000, 1'b1);
        end

        // R4 and R3: all ones up to each group top, select carry 0 then 1.
        for (int g = 0; g < 5; g++) begin
            logic [16:0] m;
            m = (17'h1 << (grp_top(g) + 1)) - 17'h1;
            drive("R4 select plain", m[15:0], 16'h0000, 1'b0);
            drive("R3 bec wrap",     m[15:0], 16'h0000, 1'b1);
            drive("R4 select bump",  m[15:0] ^ 16'h0001, 16'h0001, 1'b1);
        end

        // R3: top group plain result all ones; only the converter makes cout.
        drive("R3 top converter", 16'hF800, 16'h07FF, 1'b1);

        // R2: output holds between edges and follows one cycle later.
        for (int i = 0; i < 8; i++) begin
            logic [15:0] x, y;
            logic c;
            x = 16'($urandom); y = 16'($urandom); c = 1'($urandom);
            @(negedge clk);
            held = {cout, sum};
            a = x; b = y; cin = c;
            #1;
            check("R2 hold before edge", {cout, sum}, held);
            @(negedge clk);
            check("R2 one cycle later", {cout, sum}, ref_add(x, y, c));
        end

        // R1: random vectors.
        for (int i = 0; i < 3000; i++) begin
            drive("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule